// File: doc/BRIEF.md
# Branch Redirect and Squash Controller

This block produces the fetch address of a five-stage in-order pipeline and decides which younger instructions must be discarded when a control transfer is taken. The stage that resolves the branch supplies a taken flag and the computed target, which is the branch's own PC+4 plus its offset. The block picks the next fetch address from three choices: the sequential address (current PC plus the instruction size), the target, or the current PC held by a data-hazard stall. A taken branch always wins over a stall.

A build-time parameter selects one of two resolution schemes. In the execute-resolve scheme the branch decides in the third stage. By then two wrong-path instructions have entered the pipe: one in fetch and one in decode. Both are killed. The fetch/decode latch is cleared, and the decode-stage instruction enters the decode/execute latch as a bubble whose register-write and memory-write enables are forced low. In the decode-resolve scheme the branch decides in the second stage, and the one instruction fetched behind it is an architectural delay slot. That instruction always executes, so this scheme never squashes anything.

Top module: `brflush_ctrl`

## Requirements
- R1: While reset is active, and until the first enabled update after it, the fetch PC is 0 and both flush outputs are low.
- R2: With no taken branch and no stall, next_pc_o equals fetch_pc_o + 4, and fetch_pc_o takes that value at the next clock edge.
- R3: With a taken branch, next_pc_o equals br_target_i, and fetch_pc_o takes the target at the next clock edge.
- R4: With a stall and no taken branch, next_pc_o equals fetch_pc_o, and fetch_pc_o does not change at the next edge.
- R5: When a taken branch and a stall occur in the same cycle, the taken branch has priority: next_pc_o is the target and the PC loads it.
- R6: In execute-resolve mode (MODE = RESOLVE_EXECUTE), a taken branch raises flush_ifid_o and flush_idex_o together, in the same cycle as br_taken_i.
- R7: In execute-resolve mode, neither flush output is high while br_taken_i is low.
- R8: In decode-resolve mode (MODE = RESOLVE_DECODE), both flush outputs stay low even for a taken branch. The delay-slot instruction's write enables pass through unchanged.
- R9: When flush_idex_o is high, idex_reg_we_o and idex_mem_we_o are 0. Otherwise they equal dec_reg_we_i and dec_mem_we_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| stall_i | input | 1 | Data-hazard stall: hold the fetch PC |
| br_taken_i | input | 1 | Branch in the resolving stage is taken |
| br_target_i | input | ADDR_W | Target address of the resolving branch |
| dec_reg_we_i | input | 1 | Register-write enable of the decode-stage instruction |
| dec_mem_we_i | input | 1 | Memory-write enable of the decode-stage instruction |
| fetch_pc_o | output | ADDR_W | Address currently being fetched |
| next_pc_o | output | ADDR_W | Address to be fetched in the next cycle |
| flush_ifid_o | output | 1 | Clear the fetch/decode latch |
| flush_idex_o | output | 1 | Turn the decode-stage instruction into a bubble |
| idex_reg_we_o | output | 1 | Register-write enable sent into the decode/execute latch |
| idex_mem_we_o | output | 1 | Memory-write enable sent into the decode/execute latch |

## Verification
The two functions that can coincide are the stall hold and the taken-branch redirect. The bench raises stall_i and br_taken_i in the same cycle, both in isolation and directly after a sequential run. It judges the result by checking that next_pc_o shows the target, that the PC holds the target one edge later rather than the old address, and that the squash outputs of each mode are unaffected by the stall. A redirect that arrives while the decode instruction carries live write enables is also driven, to confirm that the bubble kills those enables in one mode and keeps them in the other.

// File: rtl/brf_pkg.sv
`timescale 1ns/1ps
package brf_pkg;

  // Stage in which a control transfer is decided.
  typedef enum logic {
    RESOLVE_EXECUTE = 1'b0,  // third stage, no delay slot, two slots squashed
    RESOLVE_DECODE  = 1'b1   // second stage, one architectural delay slot
  } resolve_mode_e;

  // Number of younger instructions killed per taken branch in each scheme.
  function automatic int unsigned squash_depth(resolve_mode_e m);
    return (m == RESOLVE_EXECUTE) ? 2 : 0;
  endfunction

endpackage

// File: rtl/brf_rst_sync.sv
`timescale 1ns/1ps
module brf_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/brf_pc_seq.sv
`timescale 1ns/1ps
module brf_pc_seq #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned INSN_BYTES = 4,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stall_i,
  input  logic              redirect_i,
  input  logic [ADDR_W-1:0] target_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic [ADDR_W-1:0] next_pc_o
);

  localparam logic [ADDR_W-1:0] PC_INC = ADDR_W'(INSN_BYTES);

  logic [ADDR_W-1:0] pc_q;
  logic [ADDR_W-1:0] pc_d;
  logic [ADDR_W-1:0] seq_pc;
  logic              pc_en;

  // Next-state selection: redirect first, then stall hold, else sequential.
  always_comb begin
    seq_pc = pc_q + PC_INC;
    if (redirect_i)   pc_d = target_i;
    else if (stall_i) pc_d = pc_q;
    else              pc_d = seq_pc;
    pc_en = redirect_i | ~stall_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pc_q <= RESET_PC;
    else if (pc_en) pc_q <= pc_d;
  end

  assign pc_o      = pc_q;
  assign next_pc_o = pc_d;

  a_r2_sequential_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!redirect_i && !stall_i) |=> (pc_q == $past(pc_q) + PC_INC));

  a_r3_redirect_loads_target: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_i |=> (pc_q == $past(target_i)));

  a_r4_stall_holds_pc: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_i && !redirect_i) |=> $stable(pc_q));

  a_r5_redirect_beats_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_i && redirect_i) |=> (pc_q == $past(target_i)));

endmodule

// File: rtl/brf_squash.sv
`timescale 1ns/1ps
module brf_squash
  import brf_pkg::*;
#(
  parameter resolve_mode_e MODE = RESOLVE_EXECUTE
) (
  input  logic clk,
  input  logic rst_n,
  input  logic taken_i,
  output logic flush_ifid_o,
  output logic flush_idex_o
);

  localparam int unsigned DEPTH = squash_depth(MODE);

  generate
    if (DEPTH == 2) begin : g_exec_resolve
      // Wrong-path work sits in fetch and in decode: kill both.
      always_comb begin
        flush_ifid_o = taken_i;
        flush_idex_o = taken_i;
      end

      a_r6_taken_kills_two: assert property (@(posedge clk) disable iff (!rst_n)
        taken_i |-> (flush_ifid_o && flush_idex_o));

      a_r7_quiet_without_taken: assert property (@(posedge clk) disable iff (!rst_n)
        !taken_i |-> (!flush_ifid_o && !flush_idex_o));
    end else begin : g_decode_resolve
      // The one instruction behind the branch is a delay slot: never kill it.
      always_comb begin
        flush_ifid_o = 1'b0;
        flush_idex_o = 1'b0;
      end

      a_r8_slot_never_flushed: assert property (@(posedge clk) disable iff (!rst_n)
        taken_i |-> (!flush_ifid_o && !flush_idex_o));
    end
  endgenerate

endmodule

// File: rtl/brf_slot_gate.sv
`timescale 1ns/1ps
module brf_slot_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic kill_i,
  input  logic reg_we_i,
  input  logic mem_we_i,
  output logic reg_we_o,
  output logic mem_we_o
);

  always_comb begin
    reg_we_o = reg_we_i & ~kill_i;
    mem_we_o = mem_we_i & ~kill_i;
  end

  a_r9_bubble_has_no_writes: assert property (@(posedge clk) disable iff (!rst_n)
    kill_i |-> (!reg_we_o && !mem_we_o));

  a_r9_live_slot_passes: assert property (@(posedge clk) disable iff (!rst_n)
    !kill_i |-> (reg_we_o == reg_we_i && mem_we_o == mem_we_i));

endmodule

// File: rtl/brflush_ctrl.sv
`timescale 1ns/1ps
module brflush_ctrl
  import brf_pkg::*;
#(
  parameter int unsigned   ADDR_W     = 32,
  parameter int unsigned   INSN_BYTES = 4,
  parameter resolve_mode_e MODE       = RESOLVE_EXECUTE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stall_i,
  input  logic              br_taken_i,
  input  logic [ADDR_W-1:0] br_target_i,
  input  logic              dec_reg_we_i,
  input  logic              dec_mem_we_i,
  output logic [ADDR_W-1:0] fetch_pc_o,
  output logic [ADDR_W-1:0] next_pc_o,
  output logic              flush_ifid_o,
  output logic              flush_idex_o,
  output logic              idex_reg_we_o,
  output logic              idex_mem_we_o
);

  localparam logic [ADDR_W-1:0] BOOT_PC = '0;

  logic rst_int_n;
  logic kill_ifid;
  logic kill_idex;

  brf_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  brf_pc_seq #(
    .ADDR_W     (ADDR_W),
    .INSN_BYTES (INSN_BYTES),
    .RESET_PC   (BOOT_PC)
  ) u_pc (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .stall_i    (stall_i),
    .redirect_i (br_taken_i),
    .target_i   (br_target_i),
    .pc_o       (fetch_pc_o),
    .next_pc_o  (next_pc_o)
  );

  brf_squash #(.MODE(MODE)) u_squash (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .taken_i      (br_taken_i),
    .flush_ifid_o (kill_ifid),
    .flush_idex_o (kill_idex)
  );

  brf_slot_gate u_gate (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .kill_i   (kill_idex),
    .reg_we_i (dec_reg_we_i),
    .mem_we_i (dec_mem_we_i),
    .reg_we_o (idex_reg_we_o),
    .mem_we_o (idex_mem_we_o)
  );

  assign flush_ifid_o = kill_ifid;
  assign flush_idex_o = kill_idex;

  // R1: the PC sits at its boot value while reset is held.
  a_r1_boot_pc: assert property (@(posedge clk)
    !rst_int_n |-> (fetch_pc_o == BOOT_PC));

endmodule

// File: tb/brflush_ctrl_test.sv
`timescale 1ns/1ps
module brflush_ctrl_test;
  import brf_pkg::*;

  localparam int AW = 32;

  logic clk = 1'b0;
  logic rst_n;
  logic stall_i, br_taken_i, dec_reg_we_i, dec_mem_we_i;
  logic [AW-1:0] br_target_i;

  logic [AW-1:0] pc_x, npc_x, pc_d, npc_d;
  logic fi_x, fd_x, rw_x, mw_x, fi_d, fd_d, rw_d, mw_d;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;  // 200 MHz

  brflush_ctrl #(.ADDR_W(AW), .MODE(RESOLVE_EXECUTE)) uut (
    .clk(clk), .rst_n(rst_n), .stall_i(stall_i), .br_taken_i(br_taken_i),
    .br_target_i(br_target_i), .dec_reg_we_i(dec_reg_we_i), .dec_mem_we_i(dec_mem_we_i),
    .fetch_pc_o(pc_x), .next_pc_o(npc_x), .flush_ifid_o(fi_x), .flush_idex_o(fd_x),
    .idex_reg_we_o(rw_x), .idex_mem_we_o(mw_x));

  brflush_ctrl #(.ADDR_W(AW), .MODE(RESOLVE_DECODE)) uut_ds (
    .clk(clk), .rst_n(rst_n), .stall_i(stall_i), .br_taken_i(br_taken_i),
    .br_target_i(br_target_i), .dec_reg_we_i(dec_reg_we_i), .dec_mem_we_i(dec_mem_we_i),
    .fetch_pc_o(pc_d), .next_pc_o(npc_d), .flush_ifid_o(fi_d), .flush_idex_o(fd_d),
    .idex_reg_we_o(rw_d), .idex_mem_we_o(mw_d));

  typedef struct {
    logic [AW-1:0] pc;
    logic [AW-1:0] npc;
    logic          kill;
    logic          rwe;
    logic          mwe;
    string         tag;
  } exp_t;

  exp_t q[$];
  event ev;
  logic [AW-1:0] model_pc;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // Driver: applies one cycle of stimulus and queues what the ports must show.
  task automatic step(input logic tk, input logic [AW-1:0] tgt, input logic st,
                      input logic rw, input logic mw, input string tag);
    exp_t e;
    @(negedge clk);
    br_taken_i = tk; br_target_i = tgt; stall_i = st;
    dec_reg_we_i = rw; dec_mem_we_i = mw;
    #1;
    e.pc   = model_pc;
    e.npc  = tk ? tgt : (st ? model_pc : model_pc + 32'd4);
    e.kill = tk;
    e.rwe  = rw;
    e.mwe  = mw;
    e.tag  = tag;
    q.push_back(e);
    ->ev;
    model_pc = e.npc;
  endtask

  // Monitor: compares both mode variants against the queued expectation.
  initial begin
    exp_t e;
    forever begin
      @ev;
      while (q.size() > 0) begin
        e = q.pop_front();
        chk(pc_x == e.pc,   e.tag, "exec fetch_pc", pc_x, e.pc);
        chk(npc_x == e.npc, e.tag, "exec next_pc",  npc_x, e.npc);
        chk(pc_d == e.pc,   e.tag, "slot fetch_pc", pc_d, e.pc);
        chk(npc_d == e.npc, e.tag, "slot next_pc",  npc_d, e.npc);
        // R6/R7: execute mode kills both younger slots exactly when taken.
        chk(fi_x == e.kill, e.tag, "exec flush_ifid R6/R7", AW'(fi_x), AW'(e.kill));
        chk(fd_x == e.kill, e.tag, "exec flush_idex R6/R7", AW'(fd_x), AW'(e.kill));
        // R9: bubble enables are zero, live enables pass.
        chk(rw_x == (e.rwe & ~e.kill), e.tag, "exec reg_we R9", AW'(rw_x), AW'(e.rwe & ~e.kill));
        chk(mw_x == (e.mwe & ~e.kill), e.tag, "exec mem_we R9", AW'(mw_x), AW'(e.mwe & ~e.kill));
        // R8: decode mode never flushes; delay slot keeps its enables.
        chk(!fi_d && !fd_d, e.tag, "slot flush R8", AW'({fi_d, fd_d}), '0);
        chk(rw_d == e.rwe && mw_d == e.mwe, e.tag, "slot enables R8",
            AW'({rw_d, mw_d}), AW'({e.rwe, e.mwe}));
      end
    end
  end

  initial begin
    #(2.5ns * 2 * 100000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; stall_i = 1'b1; br_taken_i = 1'b0; br_target_i = '0;
    dec_reg_we_i = 1'b0; dec_mem_we_i = 1'b0;
    model_pc = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state of both variants.
    chk(pc_x == '0 && pc_d == '0, "R1", "reset pc", pc_x | pc_d, '0);
    chk(!fi_x && !fd_x && !fi_d && !fd_d, "R1", "reset flush",
        AW'({fi_x, fd_x, fi_d, fd_d}), '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);  // stall held high: PC stays at 0
    chk(pc_x == '0, "R1", "pc after release", pc_x, '0);

    step(0, 32'h0,   0, 1, 0, "R2 seq");
    step(0, 32'h0,   0, 0, 1, "R2 seq");
    step(0, 32'h0,   0, 1, 1, "R2 seq");
    step(0, 32'h0,   1, 1, 0, "R4 stall");
    step(0, 32'h0,   1, 0, 0, "R4 stall");
    step(1, 32'h100, 0, 1, 1, "R3 R6 R8 R9 taken");
    step(0, 32'h0,   0, 1, 1, "R7 R9 after taken");
    step(0, 32'h0,   0, 0, 0, "R2 seq");
    step(1, 32'h2C0, 1, 1, 0, "R5 taken+stall");
    step(0, 32'h0,   1, 0, 1, "R4 stall after redirect");
    step(1, 32'h2C0, 1, 0, 1, "R5 taken+stall repeat");
    step(1, 32'h40,  0, 0, 0, "R3 back-to-back taken");
    step(1, 32'hFFC, 0, 1, 1, "R3 R6 R9 back-to-back taken");
    step(0, 32'h0,   0, 1, 1, "R2 R7 resume");
    step(0, 32'h0,   0, 0, 0, "R2 seq");
    @(negedge clk);
    finish_run();
  end

endmodule